// File: doc/BRIEF.md
# Radio Data Interrupt Control Register

This block is the 8-bit interrupt control and status register of a radio data block decoder. Software picks one of seven decoder events as the interrupt source. When the chosen event fires, the block sets a sticky interrupt flag and pulls an active-low interrupt pin low. A read of the register clears the flag. Sources tied to block timing or to traffic announcements count only while the decoder reports that it is synchronized.

The same register carries a self-clearing resynchronization command. Writing that command produces a one-cycle pulse, which sends the decoder back to its search state and rewinds the buffer address. It also reports two live values: the decoder's synchronized state, and whether the block buffer holds anything.

There are two ways to write the register. A parallel bus write always takes effect. A word arriving from the serial shifter takes effect only if its top bit (the commit bit) is set. There is no data stream through this block: every pin is a plain control or status pin, so there is no valid/ready handshake and no back-pressure.

Top module: `rdi_ctrl_reg`

## Requirements
- R1: After reset the source select, the flag, the resync pulse and the buffer address reset are all 0, and the interrupt pin is 1.
- R2: Read data layout: bit 7 and bit 5 read 0. Bit 6 is 1 exactly when the buffer count is non-zero. Bit 4 is the live synchronized input. Bits 3:1 are the source select. Bit 0 is the interrupt flag.
- R3: Source codes select events as follows. Code 0 selects nothing. Code k (1 to 7) selects `evt_i[k-1]`, where index 0 is buffer not empty, 1 buffer full, 2 block A, 3 block B, 4 block D, 5 announcement and 6 announcement on another network.
- R4: When the selected event is high at a clock edge, the flag is 1 after that edge and `irq_n` is its inverse.
- R5: Codes 3 to 7 set the flag only if `dec_synced` is 1 in the event's cycle. Codes 1 and 2 ignore `dec_synced`.
- R6: A read (`reg_rd_en`) clears the flag at the edge that ends the read cycle. If a qualifying event occurs in the same cycle, the flag stays 1.
- R7: An accepted write whose source field differs from the current select clears the flag at that edge, even if an event occurs in the same cycle. A write that keeps the same source leaves the flag alone.
- R8: An accepted write with bit 5 set makes `resync_pulse` and `buf_addr_rst` high for exactly the following cycle.
- R9: A serial load (`ser_load`) is accepted only if `ser_word` bit 7 is 1. Otherwise it changes neither the source select nor the resync outputs. A bus write in the same cycle takes priority over the serial word.
- R10: Written values of bits 7, 6, 4 and 0 have no effect. In particular, writing 1 to bit 0 does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Parallel bus write strobe |
| reg_wr_data | input | 8 | Parallel bus write data |
| reg_rd_en | input | 1 | Register read strobe (clears the flag) |
| reg_rd_data | output | 8 | Register read data |
| ser_load | input | 1 | Serial shifter word-complete strobe |
| ser_word | input | 8 | Serial shifted-in word (bit 7 = commit) |
| evt_i | input | 7 | Decoder event strobes, index = source code minus 1 |
| dec_synced | input | 1 | Decoder synchronized state |
| buf_count | input | CNT_W | Number of blocks stored in the buffer |
| irq_n | output | 1 | Active-low interrupt pin |
| resync_pulse | output | 1 | One-cycle resynchronization command |
| buf_addr_rst | output | 1 | One-cycle buffer address reset |

## Verification
The bench drives a gated source (codes 3 to 7) while the decoder is unsynchronized. A design that ignored the gate would raise the flag here. It collides a read with an event in the same cycle; a design with the wrong precedence would drop a real interrupt. It changes the source while a flag is pending and while an event fires; a wrong design would leave a stale interrupt standing. It also sends serial words without the commit bit and bus writes with bit 0 set. A wrong design would change the select, fire a resync, or raise the flag by software.

// File: rtl/rdi_pkg.sv
package rdi_pkg;

  localparam int REG_W   = 8;
  localparam int SRC_W   = 3;
  localparam int NUM_EVT = (1 << SRC_W) - 1;

  // Source select codes; order is behaviour (code k picks event k-1).
  typedef enum logic [SRC_W-1:0] {
    SRC_NONE  = 3'd0,
    SRC_BNE   = 3'd1,
    SRC_BFULL = 3'd2,
    SRC_BLKA  = 3'd3,
    SRC_BLKB  = 3'd4,
    SRC_BLKD  = 3'd5,
    SRC_ANN   = 3'd6,
    SRC_ANNX  = 3'd7
  } rdi_src_e;

  // Register image, MSB first.
  typedef struct packed {
    logic             commit;
    logic             bne;
    logic             resync;
    logic             synced;
    logic [SRC_W-1:0] src;
    logic             flag;
  } rdi_reg_t;

  // Sources at or above block A need the decoder to be synchronized.
  function automatic logic src_needs_sync(input int unsigned code);
    return code >= int'(SRC_BLKA);
  endfunction

endpackage

// File: rtl/rdi_wr_path.sv
module rdi_wr_path
  import rdi_pkg::*;
(
  input  logic             bus_wr_en,
  input  logic [REG_W-1:0] bus_wr_data,
  input  logic             ser_load,
  input  logic [REG_W-1:0] ser_word,
  input  logic [SRC_W-1:0] cur_src,
  output logic             wr_acc,
  output logic [SRC_W-1:0] nxt_src,
  output logic             src_chg,
  output logic             resync_req
);

  rdi_reg_t bus_w;
  rdi_reg_t ser_w;
  rdi_reg_t sel_w;
  logic     ser_acc;
  logic     unused_fields;

  always_comb begin
    bus_w      = rdi_reg_t'(bus_wr_data);
    ser_w      = rdi_reg_t'(ser_word);
    // serial words only count when the commit bit is set
    ser_acc    = ser_load && ser_w.commit;
    wr_acc     = bus_wr_en || ser_acc;
    // bus write wins over a serial word in the same cycle
    sel_w      = bus_wr_en ? bus_w : ser_w;
    nxt_src    = wr_acc ? sel_w.src : cur_src;
    src_chg    = wr_acc && (sel_w.src != cur_src);
    resync_req = wr_acc && sel_w.resync;
  end

  // read-only / status fields carry no write meaning
  assign unused_fields = ^{sel_w.commit, sel_w.bne, sel_w.synced, sel_w.flag};

endmodule

// File: rtl/rdi_evt_sel.sv
module rdi_evt_sel
  import rdi_pkg::*;
(
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [SRC_W-1:0]   src,
  input  logic               synced,
  output logic               hit
);

  // qual[k] is the qualified event for source code k; code 0 never fires
  logic [NUM_EVT:0] qual;

  assign qual[0] = 1'b0;

  for (genvar g = 1; g <= NUM_EVT; g++) begin : g_src
    if (src_needs_sync(g)) begin : g_gated
      assign qual[g] = evt_i[g-1] && synced;
    end else begin : g_free
      assign qual[g] = evt_i[g-1];
    end
  end

  assign hit = qual[src];

endmodule

// File: rtl/rdi_flag.sv
module rdi_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic src_chg,
  input  logic rd_clr,
  output logic flag
);

  // priority: source change clear > new event > read clear
  always_ff @(posedge clk) begin
    if (!rst_n)       flag <= 1'b0;
    else if (src_chg) flag <= 1'b0;
    else if (hit)     flag <= 1'b1;
    else if (rd_clr)  flag <= 1'b0;
  end

endmodule

// File: rtl/rdi_ctrl_reg.sv
module rdi_ctrl_reg
  import rdi_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr_en,
  input  logic [REG_W-1:0]     reg_wr_data,
  input  logic                 reg_rd_en,
  output logic [REG_W-1:0]     reg_rd_data,
  input  logic                 ser_load,
  input  logic [REG_W-1:0]     ser_word,
  input  logic [NUM_EVT-1:0]   evt_i,
  input  logic                 dec_synced,
  input  logic [CNT_W-1:0]     buf_count,
  output logic                 irq_n,
  output logic                 resync_pulse,
  output logic                 buf_addr_rst
);

  logic [SRC_W-1:0] src_q;
  logic [SRC_W-1:0] src_d;
  logic             wr_acc;
  logic             src_chg;
  logic             resync_req;
  logic             resync_q;
  logic             hit;
  logic             flag;
  rdi_reg_t         rd_img;

  rdi_wr_path u_wr (
    .bus_wr_en  (reg_wr_en),
    .bus_wr_data(reg_wr_data),
    .ser_load   (ser_load),
    .ser_word   (ser_word),
    .cur_src    (src_q),
    .wr_acc     (wr_acc),
    .nxt_src    (src_d),
    .src_chg    (src_chg),
    .resync_req (resync_req)
  );

  rdi_evt_sel u_sel (
    .evt_i (evt_i),
    .src   (src_q),
    .synced(dec_synced),
    .hit   (hit)
  );

  rdi_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit    (hit),
    .src_chg(src_chg),
    .rd_clr (reg_rd_en),
    .flag   (flag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q    <= '0;
      resync_q <= 1'b0;
    end else begin
      src_q    <= src_d;
      resync_q <= resync_req;
    end
  end

  always_comb begin
    rd_img        = '0;
    rd_img.bne    = (buf_count != '0);
    rd_img.synced = dec_synced;
    rd_img.src    = src_q;
    rd_img.flag   = flag;
  end

  assign reg_rd_data  = rd_img;
  assign irq_n        = ~flag;
  assign resync_pulse = resync_q;
  assign buf_addr_rst = resync_q;

endmodule

// File: rtl/rdi_ctrl_reg_chk.sv
module rdi_ctrl_reg_chk
  import rdi_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr_en,
  input logic [REG_W-1:0]   reg_wr_data,
  input logic               reg_rd_en,
  input logic [REG_W-1:0]   reg_rd_data,
  input logic               ser_load,
  input logic [REG_W-1:0]   ser_word,
  input logic [NUM_EVT-1:0] evt_i,
  input logic               dec_synced,
  input logic               irq_n,
  input logic               resync_pulse,
  input logic               buf_addr_rst
);

  logic             acc;
  logic [REG_W-1:0] wd;
  logic [SRC_W-1:0] cur;
  logic             sel_evt;
  logic             q_hit;

  always_comb begin
    acc     = reg_wr_en || (ser_load && ser_word[7]);
    wd      = reg_wr_en ? reg_wr_data : ser_word;
    cur     = reg_rd_data[3:1];
    sel_evt = (cur != '0) && evt_i[cur - 3'd1];
    q_hit   = sel_evt && ((cur < 3'd3) || dec_synced);
  end

  AST_ZERO_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data[7] == 1'b0) && (reg_rd_data[5] == 1'b0)); // R2
  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (q_hit && !(acc && (wd[3:1] != cur))) |=> !irq_n); // R4
  AST_UNSYNC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur >= 3'd3) && !dec_synced && irq_n && !acc) |=> irq_n); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && !q_hit && !acc) |=> irq_n); // R6
  AST_SRC_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (wd[3:1] != cur)) |=> irq_n); // R7
  AST_RESYNC_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wd[5]) |=> (resync_pulse && buf_addr_rst)); // R8
  AST_RESYNC_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && wd[5]) |=> !(resync_pulse || buf_addr_rst)); // R8
  AST_NO_COMMIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_load && !ser_word[7] && !reg_wr_en) |=> $stable(reg_rd_data[3:1])); // R9

endmodule

bind rdi_ctrl_reg rdi_ctrl_reg_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_data (reg_wr_data),
  .reg_rd_en   (reg_rd_en),
  .reg_rd_data (reg_rd_data),
  .ser_load    (ser_load),
  .ser_word    (ser_word),
  .evt_i       (evt_i),
  .dec_synced  (dec_synced),
  .irq_n       (irq_n),
  .resync_pulse(resync_pulse),
  .buf_addr_rst(buf_addr_rst)
);

// File: tb/rdi_ctrl_reg_tb_top.sv
module rdi_ctrl_reg_tb_top;

  localparam int CNT_W = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_wr_en = 1'b0;
  logic [7:0]       reg_wr_data = '0;
  logic             reg_rd_en = 1'b0;
  logic [7:0]       reg_rd_data;
  logic             ser_load = 1'b0;
  logic [7:0]       ser_word = '0;
  logic [6:0]       evt_i = '0;
  logic             dec_synced = 1'b0;
  logic [CNT_W-1:0] buf_count = '0;
  logic             irq_n;
  logic             resync_pulse;
  logic             buf_addr_rst;

  always #4 clk = ~clk;

  rdi_ctrl_reg #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_en(reg_rd_en), .reg_rd_data(reg_rd_data),
    .ser_load(ser_load), .ser_word(ser_word),
    .evt_i(evt_i), .dec_synced(dec_synced), .buf_count(buf_count),
    .irq_n(irq_n), .resync_pulse(resync_pulse), .buf_addr_rst(buf_addr_rst)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done = 0;
  logic [2:0] m_src = '0;
  logic       m_flag = 1'b0;
  logic       m_pulse = 1'b0;
  string      src_tag = "R1";
  string      flag_tag = "R1";

  task automatic chk(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // expected read value from requirement R2 layout
  function automatic logic [7:0] exp_rd();
    return {1'b0, (buf_count != '0), 1'b0, dec_synced, m_src, m_flag};
  endfunction

  task automatic check_outputs();
    logic [7:0] e;
    e = exp_rd();
    chk("R2", "status bits 7:4", {4'h0, reg_rd_data[7:4]}, {4'h0, e[7:4]});
    chk(src_tag, "source select", {5'h0, reg_rd_data[3:1]}, {5'h0, m_src});
    chk(flag_tag, "flag bit", {7'h0, reg_rd_data[0]}, {7'h0, m_flag});
    chk("R4", "irq_n", {7'h0, irq_n}, {7'h0, ~m_flag});
    chk("R8", "resync_pulse", {7'h0, resync_pulse}, {7'h0, m_pulse});
    chk("R8", "buf_addr_rst", {7'h0, buf_addr_rst}, {7'h0, m_pulse});
  endtask

  // model of the next state, written from the requirements
  task automatic model_step();
    logic       acc, hit, sel, chg;
    logic [7:0] wd;
    acc = reg_wr_en || (ser_load && ser_word[7]);            // R9
    wd  = reg_wr_en ? reg_wr_data : ser_word;
    sel = (m_src != 3'd0) && evt_i[m_src - 3'd1];            // R3
    hit = sel && ((m_src < 3'd3) || dec_synced);             // R5
    chg = acc && (wd[3:1] != m_src);                         // R7
    if (chg)            begin m_flag = 1'b0; flag_tag = "R7"; end
    else if (hit)       begin m_flag = 1'b1; flag_tag = reg_rd_en ? "R6" : "R4"; end
    else if (reg_rd_en) begin m_flag = 1'b0; flag_tag = "R6"; end
    else if (sel)       flag_tag = "R5";
    else if (acc)       flag_tag = "R10";
    else                flag_tag = "R3";
    src_tag = (ser_load && !reg_wr_en) ? "R9" : "R3";
    if (acc) m_src = wd[3:1];
    m_pulse = acc && wd[5];                                  // R8
  endtask

  task automatic cycle();
    #1;
    check_outputs();
    model_step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    reg_wr_en = 0; reg_wr_data = '0; reg_rd_en = 0;
    ser_load = 0; ser_word = '0; evt_i = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog run did not finish");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "reset read", reg_rd_data, 8'h00);
    chk("R1", "reset irq_n", {7'h0, irq_n}, 8'h01);
    chk("R1", "reset resync", {6'h0, resync_pulse, buf_addr_rst}, 8'h00);
    @(negedge clk);
    rst_n = 1;

    // source 1 (buffer not empty), event, then read clear
    buf_count = 6'd3;
    reg_wr_en = 1; reg_wr_data = 8'h02; cycle(); idle();
    evt_i = 7'b0000001; cycle(); idle();
    reg_rd_en = 1; cycle(); idle();
    cycle();

    // R5: block A selected while unsynchronized
    reg_wr_en = 1; reg_wr_data = 8'h06; cycle(); idle();
    dec_synced = 0; evt_i = 7'b0000100; cycle(); idle();
    cycle();
    dec_synced = 1; evt_i = 7'b0000100; cycle(); idle();
    // R6: read and event together -> flag stays
    reg_rd_en = 1; evt_i = 7'b0000100; cycle(); idle();
    cycle();
    // R10: same-source write with bit 0 and status bits set leaves flag, then read clears
    reg_rd_en = 1; cycle(); idle();
    reg_wr_en = 1; reg_wr_data = 8'hD7; cycle(); idle();
    cycle();

    // R7: flag pending then source change with concurrent event
    evt_i = 7'b0000100; cycle(); idle();
    reg_wr_en = 1; reg_wr_data = 8'h08; evt_i = 7'b0001100; cycle(); idle();
    cycle();

    // R9: serial without commit, with resync and new source
    ser_load = 1; ser_word = 8'h2A; cycle(); idle();
    cycle();
    // serial with commit: source change and resync (R8)
    ser_load = 1; ser_word = 8'hAE; cycle(); idle();
    cycle();
    // bus and serial in same cycle: bus wins
    reg_wr_en = 1; reg_wr_data = 8'h04; ser_load = 1; ser_word = 8'hAE; cycle(); idle();
    cycle();
    buf_count = '0; cycle();

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      reg_wr_en   = ($urandom % 10) == 0;
      reg_wr_data = 8'($urandom);
      ser_load    = ($urandom % 10) == 0;
      ser_word    = 8'($urandom);
      reg_rd_en   = ($urandom % 4) == 0;
      evt_i       = 7'($urandom) & 7'($urandom);
      dec_synced  = ($urandom % 4) != 0;
      buf_count   = (($urandom % 3) == 0) ? '0 : CNT_W'($urandom);
      cycle();
    end
    idle();
    cycle();
    finish_run();
  end

endmodule